// File: doc/BRIEF.md
# Floating-point exception control register

This block holds the 64-bit control and status word that governs floating-point exception handling, together with the logic that turns each operation's exception report into a trap decision. Software reads and writes the word through a simple register port. The word holds the sticky exception flags, the per-condition trap-disable controls, the underflow flush control and the dynamic rounding mode.

Every completing floating-point or conversion operation presents its raw conditions on `op_exc` with `op_valid`. The block records the conditions in the sticky flags. For the four conditions that can trap, it checks the disable controls. It then either raises a one-cycle trap with a one-hot cause, or names the non-trapping result that the datapath must substitute. The rounding-mode field drives `rnd_mode`. The datapath uses it only for instructions that ask for dynamic rounding.

Top module: `fp_exc_ctrl`

## Requirements
- R1: After reset, `csr_rdata` is 0, `rnd_mode` is 00, `trap_valid` is 0, `trap_cause` is 0 and `subst_sel` is 0.
- R2: When `csr_we` is high, the word is loaded from `csr_wdata` in bits 61..49. All other bits read as zero and ignore writes. The new value is visible on `csr_rdata` in the cycle after the write edge.
- R3: Flag bits are sticky. For a valid operation, `op_exc[i]` sets word bit 52+i. The `op_exc` order is bit0 invalid, bit1 divide-by-zero, bit2 overflow, bit3 underflow, bit4 inexact, bit5 integer overflow. A set flag stays set until a write clears it. Conditions presented without `op_valid` change nothing.
- R4: When a write and a valid operation fall in the same cycle, the stored value is the masked write data ORed with the newly raised flags.
- R5: `rnd_mode` always equals word bits 59:58. The codes are 00 toward zero, 01 toward minus infinity, 10 to nearest and 11 toward plus infinity.
- R6: Overflow traps when word bit 51 is 0. When bit 51 is 1, overflow raises no trap and selects substitute code 3.
- R7: Divide-by-zero traps when word bit 50 is 0. When bit 50 is 1, it raises no trap and selects substitute code 2.
- R8: An invalid condition is suppressed only when word bit 49 is 1 and `op_inv_fixable` is high. It then selects substitute code 1. Otherwise it traps.
- R9: Underflow traps when word bit 61 is 0, whatever the value of bit 60. It also traps when bit 61 is 1 and bit 60 is 0. When both bits are 1, it raises no trap and selects substitute code 4, which means +0.0.
- R10: `trap_cause` is one-hot and names the highest-priority trapping condition. The order is invalid (bit0), then divide-by-zero (bit1), then overflow (bit2), then underflow (bit3). A substitute code is given only when nothing traps. It is the code of the highest-priority suppressed condition, and 0 otherwise. Inexact and integer overflow never trap.
- R11: The trap decision uses the word value from before the operation's edge. `trap_valid`, `trap_cause` and `subst_sel` appear in the cycle after a valid operation and last one cycle. They are zero after any cycle without `op_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 64 | Register write data |
| csr_rdata | output | 64 | Current register value |
| op_valid | input | 1 | Operation completion strobe |
| op_exc | input | 6 | Raw exception conditions of the operation |
| op_inv_fixable | input | 1 | Datapath can form the correct result for an invalid condition |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_cause | output | 4 | One-hot trap cause |
| subst_sel | output | 3 | Substitute result code (0 none) |
| rnd_mode | output | 2 | Dynamic rounding mode |

## Verification
A write or a flag update shows on `csr_rdata` one edge after the cycle that presents it. The trap pulse, cause and substitute code are registered, so they also appear exactly one edge after the operation, and they are decided from the word as it stood before that edge. The bench drives inputs at the falling edge and advances its reference model on the rising edge. It compares every output at the next falling edge, so each result is checked in the cycle it is due and in no other.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int NUM_EXC  = 6;
  localparam int NUM_TRAP = 4;
  localparam int FIELD_LO = 49;
  localparam int FIELD_HI = 61;
  localparam int DIS_INV  = 49;
  localparam int DIS_DZE  = 50;
  localparam int DIS_OVF  = 51;
  localparam int FLG_LO   = 52;
  localparam int RND_LO   = 58;
  localparam int UNF_ZERO = 60;
  localparam int UNF_DIS  = 61;
  localparam int SUB_W    = 3;

  typedef enum logic [SUB_W-1:0] {
    SUB_NONE = 3'd0,
    SUB_QNAN = 3'd1,
    SUB_INF  = 3'd2,
    SUB_OVF  = 3'd3,
    SUB_ZERO = 3'd4
  } subst_e;
endpackage

// File: rtl/fpx_csr.sv
module fpx_csr
  import fpx_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              set_valid,
  input  logic [NUM_EXC-1:0] set_flags,
  output logic [DATA_W-1:0] q
);
  localparam int FIELD_W = FIELD_HI - FIELD_LO + 1;
  localparam logic [DATA_W-1:0] MASK =
    ((DATA_W'(1) << FIELD_W) - DATA_W'(1)) << FIELD_LO;

  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] raised;
  logic [DATA_W-1:0] d;
  logic              en;

  always_comb begin
    base   = we ? (wdata & MASK) : q;
    raised = set_valid ? (DATA_W'(set_flags) << FLG_LO) : '0;
    d      = base | raised;
    en     = we | set_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end
endmodule

// File: rtl/fpx_trap_decide.sv
module fpx_trap_decide
  import fpx_pkg::*;
(
  input  logic                en,
  input  logic [NUM_TRAP-1:0] exc,
  input  logic                inv_ok,
  input  logic                dis_inv,
  input  logic                dis_dze,
  input  logic                dis_ovf,
  input  logic                unf_dis,
  input  logic                unf_zero,
  output logic                trap_req,
  output logic [NUM_TRAP-1:0] cause,
  output subst_e              subst
);
  logic [NUM_TRAP-1:0] suppress;
  logic [NUM_TRAP-1:0] trapping;
  logic [NUM_TRAP-1:0] quiet;

  always_comb begin
    suppress = {unf_dis & unf_zero, dis_ovf, dis_dze, dis_inv & inv_ok};
    trapping = exc & ~suppress & {NUM_TRAP{en}};
    quiet    = exc &  suppress & {NUM_TRAP{en}};
    trap_req = |trapping;
    cause    = trapping & (~trapping + NUM_TRAP'(1));
    subst    = SUB_NONE;
    if (!trap_req) begin
      for (int i = NUM_TRAP - 1; i >= 0; i--) begin
        if (quiet[i]) begin
          case (i)
            0:       subst = SUB_QNAN;
            1:       subst = SUB_INF;
            2:       subst = SUB_OVF;
            default: subst = SUB_ZERO;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/fpx_out_reg.sv
module fpx_out_reg
  import fpx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trap_d,
  input  logic [NUM_TRAP-1:0] cause_d,
  input  subst_e              subst_d,
  output logic                trap_q,
  output logic [NUM_TRAP-1:0] cause_q,
  output subst_e              subst_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q  <= 1'b0;
      cause_q <= '0;
      subst_q <= SUB_NONE;
    end else begin
      trap_q  <= trap_d;
      cause_q <= cause_d;
      subst_q <= subst_d;
    end
  end
endmodule

// File: rtl/fp_exc_ctrl.sv
module fp_exc_ctrl
  import fpx_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  input  logic              op_valid,
  input  logic [NUM_EXC-1:0] op_exc,
  input  logic              op_inv_fixable,
  output logic              trap_valid,
  output logic [NUM_TRAP-1:0] trap_cause,
  output logic [SUB_W-1:0]  subst_sel,
  output logic [1:0]        rnd_mode
);
  logic [DATA_W-1:0]   word_q;
  logic                trap_d;
  logic [NUM_TRAP-1:0] cause_d;
  subst_e              subst_d;
  subst_e              subst_q;

  fpx_csr #(.DATA_W(DATA_W)) u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (csr_we),
    .wdata     (csr_wdata),
    .set_valid (op_valid),
    .set_flags (op_exc),
    .q         (word_q)
  );

  fpx_trap_decide u_decide (
    .en       (op_valid),
    .exc      (op_exc[NUM_TRAP-1:0]),
    .inv_ok   (op_inv_fixable),
    .dis_inv  (word_q[DIS_INV]),
    .dis_dze  (word_q[DIS_DZE]),
    .dis_ovf  (word_q[DIS_OVF]),
    .unf_dis  (word_q[UNF_DIS]),
    .unf_zero (word_q[UNF_ZERO]),
    .trap_req (trap_d),
    .cause    (cause_d),
    .subst    (subst_d)
  );

  fpx_out_reg u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .trap_d  (trap_d),
    .cause_d (cause_d),
    .subst_d (subst_d),
    .trap_q  (trap_valid),
    .cause_q (trap_cause),
    .subst_q (subst_q)
  );

  assign csr_rdata = word_q;
  assign subst_sel = subst_q;
  assign rnd_mode  = word_q[RND_LO+1:RND_LO];
endmodule

// File: rtl/fp_exc_ctrl_chk.sv
module fp_exc_ctrl_chk
  import fpx_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_we,
  input logic              op_valid,
  input logic [NUM_EXC-1:0] op_exc,
  input logic              op_inv_fixable,
  input logic [DATA_W-1:0] csr_rdata,
  input logic              trap_valid,
  input logic [NUM_TRAP-1:0] trap_cause,
  input logic [SUB_W-1:0]  subst_sel
);
  localparam int FIELD_W = FIELD_HI - FIELD_LO + 1;
  localparam logic [DATA_W-1:0] MASK =
    ((DATA_W'(1) << FIELD_W) - DATA_W'(1)) << FIELD_LO;

  // R2: bits outside the defined fields stay zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata & ~MASK) == '0);

  // R3: without a write, no flag falls
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_we |=> (($past(csr_rdata[FLG_LO+NUM_EXC-1:FLG_LO]) &
                  ~csr_rdata[FLG_LO+NUM_EXC-1:FLG_LO]) == '0));

  // R6: a lone overflow with its trap enabled traps with the overflow cause
  a_r6_ovf_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_exc[3:0] == 4'b0100 && !csr_rdata[DIS_OVF])
      |=> (trap_valid && trap_cause == 4'b0100));

  // R9: underflow with flush-to-zero fully enabled gives +0 and no trap
  a_r9_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_exc[3:0] == 4'b1000 && csr_rdata[UNF_DIS] && csr_rdata[UNF_ZERO])
      |=> (!trap_valid && subst_sel == SUB_ZERO));

  // R8: an invalid condition the datapath cannot fix always traps
  a_r8_inv_unfixable: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_exc[0] && !op_inv_fixable) |=> (trap_valid && trap_cause[0]));

  // R10: a trap carries exactly one cause bit and no substitute code
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> ($countones(trap_cause) == 1 && subst_sel == SUB_NONE));

  // R11: outputs stay quiet after a cycle without an operation
  a_r11_no_op_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!trap_valid && trap_cause == '0 && subst_sel == SUB_NONE));
endmodule

bind fp_exc_ctrl fp_exc_ctrl_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/fp_exc_ctrl_bench.sv
module fp_exc_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        op_valid = 1'b0;
  logic [5:0]  op_exc = '0;
  logic        op_inv_fixable = 1'b0;
  logic        trap_valid;
  logic [3:0]  trap_cause;
  logic [2:0]  subst_sel;
  logic [1:0]  rnd_mode;

  localparam logic [63:0] DEF_MASK = 64'h3FFE_0000_0000_0000;

  always #5 clk = ~clk;

  fp_exc_ctrl u_fp_exc_ctrl (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .op_valid(op_valid), .op_exc(op_exc),
    .op_inv_fixable(op_inv_fixable), .trap_valid(trap_valid),
    .trap_cause(trap_cause), .subst_sel(subst_sel), .rnd_mode(rnd_mode)
  );

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // Reference model
  logic [63:0] m_word;
  bit          m_trap;
  logic [3:0]  m_cause;
  int          m_sub;
  int          first_trap;
  int          first_quiet;
  bit          quiet_i;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_word = '0; m_trap = 0; m_cause = '0; m_sub = 0;
    end else begin
      m_trap = 0; m_cause = '0; m_sub = 0;
      first_trap = -1; first_quiet = -1;
      if (op_valid) begin
        for (int i = 0; i < 4; i++) begin
          if (op_exc[i]) begin
            case (i)
              0: quiet_i = m_word[49] && op_inv_fixable;
              1: quiet_i = m_word[50];
              2: quiet_i = m_word[51];
              default: quiet_i = m_word[61] && m_word[60];
            endcase
            if (!quiet_i && first_trap < 0) first_trap = i;
            if (quiet_i && first_quiet < 0) first_quiet = i;
          end
        end
        if (first_trap >= 0) begin
          m_trap = 1; m_cause = 4'b0001 << first_trap;
        end else if (first_quiet >= 0) begin
          m_sub = first_quiet + 1;
        end
      end
      if (csr_we) m_word = csr_wdata & DEF_MASK;
      if (op_valid) m_word = m_word | (64'(op_exc) << 52);
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      chk(cur_req, "csr_rdata", csr_rdata, m_word);
      chk("R5", "rnd_mode", 64'(rnd_mode), 64'(m_word[59:58]));
      chk(cur_req, "trap_valid", 64'(trap_valid), 64'(m_trap));
      chk(cur_req, "trap_cause", 64'(trap_cause), 64'(m_cause));
      chk(cur_req, "subst_sel", 64'(subst_sel), 64'(m_sub));
    end
  end

  task automatic idle();
    @(negedge clk);
    csr_we = 0; op_valid = 0; op_exc = '0; op_inv_fixable = 0;
  endtask

  task automatic wr(logic [63:0] v);
    @(negedge clk);
    csr_we = 1; csr_wdata = v; op_valid = 0; op_exc = '0;
    @(negedge clk);
    csr_we = 0;
  endtask

  task automatic op(logic [5:0] e, bit fix);
    @(negedge clk);
    csr_we = 0; op_valid = 1; op_exc = e; op_inv_fixable = fix;
    @(negedge clk);
    op_valid = 0; op_exc = '0; op_inv_fixable = 0;
  endtask

  task automatic summary();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    checks++; failures++;
    $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
    summary();
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    chk("R1", "reset rdata", csr_rdata, 64'h0);
    chk("R1", "reset trap", 64'(trap_valid), 64'h0);
    rst_n = 1;
    idle();

    cur_req = "R2";
    wr(64'hFFFF_FFFF_FFFF_FFFF);
    chk("R2", "masked readback", csr_rdata, DEF_MASK);
    wr(64'hC001_0000_0000_0001);
    chk("R2", "reserved ignored", csr_rdata, 64'h0);

    cur_req = "R5";
    for (int m = 0; m < 4; m++) begin
      wr(64'(m) << 58);
      chk("R5", "rounding code", 64'(rnd_mode), 64'(m));
    end
    wr(64'h0);

    cur_req = "R3";
    for (int i = 0; i < 6; i++) op(6'b1 << i, 0);
    chk("R3", "all flags sticky", csr_rdata, 64'h03F0_0000_0000_0000);
    wr(64'h0);
    @(negedge clk);
    op_valid = 0; op_exc = 6'h3F;
    idle();
    chk("R3", "no valid no flag", csr_rdata, 64'h0);

    cur_req = "R4";
    @(negedge clk);
    csr_we = 1; csr_wdata = 64'h0C00_0000_0000_0000; op_valid = 1; op_exc = 6'b000100;
    idle();
    chk("R4", "merged write", csr_rdata, 64'h0C40_0000_0000_0000);
    wr(64'h0);

    cur_req = "R6";
    op(6'b000100, 0);
    wr(64'(1) << 51);
    op(6'b000100, 0);

    cur_req = "R7";
    wr(64'h0);
    op(6'b000010, 0);
    wr(64'(1) << 50);
    op(6'b000010, 0);

    cur_req = "R8";
    wr(64'h0);
    op(6'b000001, 1);
    wr(64'(1) << 49);
    op(6'b000001, 0);
    op(6'b000001, 1);

    cur_req = "R9";
    for (int u = 0; u < 4; u++) begin
      wr(64'(u) << 60);
      op(6'b001000, 0);
    end

    cur_req = "R10";
    wr(64'h0);
    op(6'b001111, 0);
    op(6'b110000, 0);
    wr(64'h3002_0000_0000_0000 | (64'(1) << 51));
    op(6'b001100, 0);
    op(6'b001110, 0);
    wr(64'h300E_0000_0000_0000);
    op(6'b001111, 1);

    cur_req = "R11";
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      csr_we = ($urandom_range(0, 7) == 0);
      csr_wdata = {$urandom, $urandom};
      op_valid = ($urandom_range(0, 2) != 0);
      op_exc = 6'($urandom);
      op_inv_fixable = 1'($urandom);
    end
    idle();
    idle();
    summary();
  end
endmodule